// File: doc/BRIEF.md
# Processor Exception Control Unit

This unit sits beside the control sequencer of a simple multi-cycle processor and takes over the next-PC choice whenever an exception has to be entered or left. Two kinds of exception reach it. Synchronous traps (an undefined instruction or an arithmetic overflow) are raised by the datapath for the instruction at `pc_i`. An asynchronous interrupt request can arrive at any time and is only honoured while interrupts are enabled. When an exception is taken, the unit does four things at once:

- it latches a cause code and the PC to resume at;
- it pushes the current privilege and interrupt-enable bits onto a one-deep stack;
- it enters kernel mode with interrupts masked;
- in the following cycle it drives a one-cycle redirect towards the handler.

The handler address comes from one of two sources, chosen by `vec_mode_i`. It is either a single fixed entry point or a vectored slot of 32 instructions per cause. A return request pops the saved mode bits and redirects to the saved PC in one step, so the mode, the interrupt enable and the PC change together.

The sequencer has four states:

| State | Meaning | Transitions out |
|-------|---------|-----------------|
| `ST_IDLE` | User code is running. | To `ST_TAKE` on any accepted request. |
| `ST_TAKE` | One-cycle redirect to the handler. | Always to `ST_SERVE`. |
| `ST_SERVE` | A handler is running. | To `ST_TAKE` on an accepted request; to `ST_RESUME` on a return with no request. |
| `ST_RESUME` | One-cycle redirect to the saved PC. | To `ST_SERVE` if the restored mode is kernel, otherwise to `ST_IDLE`. |

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the outputs are:
  - `redirect_o` = 0, `kernel_o` = 0 (user mode) and `int_en_o` = 1;
  - `cause_o` = 0 and `epc_o` = 0.
- R2: A request accepted at a clock edge does three things:
  - it stores `pc_i` of that cycle in `epc_o`;
  - it sets `kernel_o` = 1 and `int_en_o` = 0;
  - it raises `redirect_o` in the cycle after that edge.
- R3: The cause codes are 0 for an undefined instruction, 1 for an arithmetic overflow and 2 for an interrupt. When requests arrive together, the lowest code wins, so any trap wins over the interrupt.
- R4: The interrupt is taken only while `int_en_o` = 1. A trap is taken whatever the value of `int_en_o`.
- R5: With `vec_mode_i` = 0, the handler redirect address is the parameter `HANDLER_BASE` (default 0x0000_0C00).
- R6: With `vec_mode_i` = 1, the handler redirect address is 0x80 + (cause << 7). This gives 0x80, 0x100 and 0x180 for the three causes.
- R7: A return request while a handler runs does the following:
  - in the next cycle it raises `redirect_o` with address `epc_o`;
  - at the same edge it restores `kernel_o` and `int_en_o` to their values before the matching entry.
- R8: `redirect_o` is high for exactly one cycle. Any request or return that arrives during a redirect cycle is ignored.
- R9: A return request while no handler runs is ignored. A trap that arrives in the same cycle as a return wins over the return.
- R10: A trap taken inside a handler does the following:
  - it overwrites `epc_o` and pushes kernel mode with interrupts masked onto the stack, so the next return resumes in kernel mode with interrupts masked;
  - that return resets the stack to user mode with interrupts enabled, so a second return goes back to user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_undef_i | input | 1 | Undefined-instruction trap for the instruction at `pc_i` |
| trap_ovf_i | input | 1 | Arithmetic-overflow trap for the instruction at `pc_i` |
| irq_i | input | 1 | External interrupt request (level) |
| eret_i | input | 1 | Return-from-exception request |
| vec_mode_i | input | 1 | 0: fixed handler entry, 1: vectored entry |
| pc_i | input | PC_W | PC to save when an exception is taken |
| redirect_o | output | 1 | Next-PC override valid (one cycle) |
| redirect_pc_o | output | PC_W | Next-PC override value |
| kernel_o | output | 1 | 1 = kernel mode, 0 = user mode |
| int_en_o | output | 1 | Interrupt enable |
| cause_o | output | 2 | Cause code of the last exception taken |
| epc_o | output | PC_W | Saved exception PC |

## Verification
The hardest situation to reach is a return from a nested trap. It needs the following:
- a trap while a handler is already running;
- a return that comes back into kernel mode, which the sequencer must treat as still inside a handler;
- a second return that must land in user mode with interrupts enabled.

The bench drives two traps with different PCs and then two returns, checking the mode bits and the redirect address after each one. Masked interrupts and requests that fall in a redirect cycle are reached the same way: the bench holds the request exactly in the cycle where the sequencer must drop it, then checks that no redirect follows and that the cause and saved PC are unchanged.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TAKE   = 2'd1,
        ST_SERVE  = 2'd2,
        ST_RESUME = 2'd3
    } exc_state_e;

    typedef struct packed {
        logic kernel;
        logic ie;
    } mode_bits_t;

    localparam mode_bits_t MODE_RESET = '{kernel: 1'b0, ie: 1'b1};

    localparam int CODE_UNDEF = 0;
    localparam int CODE_OVF   = 1;
    localparam int CODE_IRQ   = 2;
    localparam int NUM_CODES  = 3;

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
    parameter int NUM_REQ = 3,
    parameter int CODE_W  = 2
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic               any_o,
    output logic [CODE_W-1:0]  code_o
);

    always_comb begin
        any_o  = |req_i;
        code_o = '0;
        // Walk from the highest index down so the lowest set index is kept.
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       pop_i,
    output mode_bits_t cur_o,
    output mode_bits_t prev_o
);

    mode_bits_t cur_q;
    mode_bits_t prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= MODE_RESET;
            prev_q <= MODE_RESET;
        end else if (push_i) begin
            prev_q <= cur_q;
            cur_q  <= '{kernel: 1'b1, ie: 1'b0};
        end else if (pop_i) begin
            cur_q  <= prev_q;
            prev_q <= MODE_RESET;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen #(
    parameter int              PC_W         = 32,
    parameter int              NUM_SLOT     = 3,
    parameter int              CODE_W       = 2,
    parameter logic [PC_W-1:0] HANDLER_BASE = 32'h0000_0C00,
    parameter logic [PC_W-1:0] VEC_BASE     = 32'h0000_0080,
    parameter int              VEC_SHIFT    = 7
) (
    input  logic              vec_mode_i,
    input  logic              use_epc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PC_W-1:0]   epc_i,
    output logic [PC_W-1:0]   target_o
);

    logic [PC_W-1:0] slot_addr [NUM_SLOT];
    logic [PC_W-1:0] vec_addr;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        assign slot_addr[g] = VEC_BASE + (PC_W'(g) << VEC_SHIFT);
    end

    always_comb begin
        vec_addr = HANDLER_BASE;
        for (int i = 0; i < NUM_SLOT; i++) begin
            if (code_i == CODE_W'(i)) begin
                vec_addr = slot_addr[i];
            end
        end
    end

    always_comb begin
        if (use_epc_i) begin
            target_o = epc_i;
        end else if (vec_mode_i) begin
            target_o = vec_addr;
        end else begin
            target_o = HANDLER_BASE;
        end
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] HANDLER_BASE = 32'h0000_0C00,
    parameter logic [PC_W-1:0] VEC_BASE     = 32'h0000_0080,
    parameter int              VEC_SHIFT    = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_undef_i,
    input  logic            trap_ovf_i,
    input  logic            irq_i,
    input  logic            eret_i,
    input  logic            vec_mode_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic            kernel_o,
    output logic            int_en_o,
    output logic [1:0]      cause_o,
    output logic [PC_W-1:0] epc_o
);

    localparam int NUM_REQ = NUM_CODES;
    localparam int CODE_W  = $clog2(NUM_REQ);

    exc_state_e        state_q;
    exc_state_e        state_d;
    logic              take;
    logic              ret;
    logic              any_req;
    logic [CODE_W-1:0] win_code;
    logic [NUM_REQ-1:0] req_vec;
    logic [CODE_W-1:0] cause_q;
    logic [PC_W-1:0]   epc_q;
    logic              use_epc;
    mode_bits_t        cur_mode;
    mode_bits_t        prev_mode;

    // Interrupts are gated by the live enable bit; traps are never gated.
    always_comb begin
        req_vec             = '0;
        req_vec[CODE_UNDEF] = trap_undef_i;
        req_vec[CODE_OVF]   = trap_ovf_i;
        req_vec[CODE_IRQ]   = irq_i & cur_mode.ie;
    end

    exc_prio_sel #(
        .NUM_REQ (NUM_REQ),
        .CODE_W  (CODE_W)
    ) u_prio (
        .req_i  (req_vec),
        .any_o  (any_req),
        .code_o (win_code)
    );

    exc_mode_stack u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (take),
        .pop_i  (ret),
        .cur_o  (cur_mode),
        .prev_o (prev_mode)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and the entry/return strobes.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        ret     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    take    = 1'b1;
                    state_d = ST_TAKE;
                end
            end
            ST_TAKE: begin
                state_d = ST_SERVE;
            end
            ST_SERVE: begin
                if (any_req) begin
                    take    = 1'b1;
                    state_d = ST_TAKE;
                end else if (eret_i) begin
                    ret     = 1'b1;
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                state_d = cur_mode.kernel ? ST_SERVE : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Cause and saved PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take) begin
            cause_q <= win_code;
            epc_q   <= pc_i;
        end
    end

    // Outputs.
    always_comb begin
        redirect_o = 1'b0;
        use_epc    = 1'b0;
        unique case (state_q)
            ST_TAKE: begin
                redirect_o = 1'b1;
            end
            ST_RESUME: begin
                redirect_o = 1'b1;
                use_epc    = 1'b1;
            end
            default: begin
                redirect_o = 1'b0;
            end
        endcase
    end

    exc_target_gen #(
        .PC_W         (PC_W),
        .NUM_SLOT     (NUM_REQ),
        .CODE_W       (CODE_W),
        .HANDLER_BASE (HANDLER_BASE),
        .VEC_BASE     (VEC_BASE),
        .VEC_SHIFT    (VEC_SHIFT)
    ) u_target (
        .vec_mode_i (vec_mode_i),
        .use_epc_i  (use_epc),
        .code_i     (cause_q),
        .epc_i      (epc_q),
        .target_o   (redirect_pc_o)
    );

    assign kernel_o = cur_mode.kernel;
    assign int_en_o = cur_mode.ie;
    assign cause_o  = 2'(cause_q);
    assign epc_o    = epc_q;

    // The previous-mode copy is kept only for the return path.
    logic unused_prev;
    assign unused_prev = ^prev_mode;

endmodule

// File: rtl/exc_ctrl_checks.sv
module exc_ctrl_checks
    import exc_pkg::*;
#(
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] HANDLER_BASE = 32'h0000_0C00,
    parameter logic [PC_W-1:0] VEC_BASE     = 32'h0000_0080,
    parameter int              VEC_SHIFT    = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_undef_i,
    input logic            trap_ovf_i,
    input logic            irq_i,
    input logic            eret_i,
    input logic            vec_mode_i,
    input logic [PC_W-1:0] pc_i,
    input logic            redirect_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic            kernel_o,
    input logic            int_en_o,
    input logic [1:0]      cause_o,
    input logic [PC_W-1:0] epc_o,
    input exc_state_e      state_q
);

    logic accepting;
    assign accepting = (state_q == ST_IDLE) || (state_q == ST_SERVE);

    p_entry_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE) |-> (kernel_o && !int_en_o));

    p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE) |-> (epc_o == $past(pc_i)));

    p_cause_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o != 2'd3);

    p_masked_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && irq_i && !int_en_o && !trap_undef_i && !trap_ovf_i && !eret_i)
        |=> !redirect_o);

    p_trap_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && (trap_undef_i || trap_ovf_i)) |=> (redirect_o && kernel_o));

    p_fixed_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE && !vec_mode_i) |-> (redirect_pc_o == HANDLER_BASE));

    p_vector_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE && vec_mode_i)
        |-> (redirect_pc_o == VEC_BASE + (PC_W'(cause_o) << VEC_SHIFT)));

    p_return_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME) |-> (redirect_o && redirect_pc_o == epc_o));

    p_one_cycle_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    p_idle_eret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && eret_i && !trap_undef_i && !trap_ovf_i
         && !(irq_i && int_en_o)) |=> !redirect_o);

endmodule

bind exc_ctrl_unit exc_ctrl_checks #(
    .PC_W         (PC_W),
    .HANDLER_BASE (HANDLER_BASE),
    .VEC_BASE     (VEC_BASE),
    .VEC_SHIFT    (VEC_SHIFT)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_undef_i  (trap_undef_i),
    .trap_ovf_i    (trap_ovf_i),
    .irq_i         (irq_i),
    .eret_i        (eret_i),
    .vec_mode_i    (vec_mode_i),
    .pc_i          (pc_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .kernel_o      (kernel_o),
    .int_en_o      (int_en_o),
    .cause_o       (cause_o),
    .epc_o         (epc_o),
    .state_q       (state_q)
);

// File: tb/tb_exc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_exc_ctrl_unit;

    localparam int          PC_W = 32;
    localparam logic [31:0] FIX  = 32'h0000_0C00;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_undef_i = 1'b0;
    logic            trap_ovf_i = 1'b0;
    logic            irq_i = 1'b0;
    logic            eret_i = 1'b0;
    logic            vec_mode_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic            redirect_o;
    logic [PC_W-1:0] redirect_pc_o;
    logic            kernel_o;
    logic            int_en_o;
    logic [1:0]      cause_o;
    logic [PC_W-1:0] epc_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    exc_ctrl_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trap_undef_i  (trap_undef_i),
        .trap_ovf_i    (trap_ovf_i),
        .irq_i         (irq_i),
        .eret_i        (eret_i),
        .vec_mode_i    (vec_mode_i),
        .pc_i          (pc_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .kernel_o      (kernel_o),
        .int_en_o      (int_en_o),
        .cause_o       (cause_o),
        .epc_o         (epc_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive inputs at the falling edge, then observe just after the rising edge.
    task automatic step(input logic u, input logic o, input logic i, input logic e,
                        input logic [31:0] pc);
        @(negedge clk);
        trap_undef_i = u;
        trap_ovf_i   = o;
        irq_i        = i;
        eret_i       = e;
        pc_i         = pc;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic leave();
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 redirect", 32'(redirect_o), 32'd0);
        chk("R1 kernel",   32'(kernel_o),   32'd0);
        chk("R1 int_en",   32'(int_en_o),   32'd1);
        chk("R1 cause",    32'(cause_o),    32'd0);
        chk("R1 epc",      epc_o,           32'd0);
    endtask

    task automatic t_fixed_entry_and_return();
        vec_mode_i = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1000);
        chk("R2 redirect",  32'(redirect_o), 32'd1);
        chk("R5 fixed pc",  redirect_pc_o,   FIX);
        chk("R2 kernel",    32'(kernel_o),   32'd1);
        chk("R2 int_en",    32'(int_en_o),   32'd0);
        chk("R3 undef code", 32'(cause_o),   32'd0);
        chk("R2 epc",       epc_o,           32'h0000_1000);
        idle();
        chk("R8 one cycle", 32'(redirect_o), 32'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R7 redirect",  32'(redirect_o), 32'd1);
        chk("R7 epc pc",    redirect_pc_o,   32'h0000_1000);
        chk("R7 kernel",    32'(kernel_o),   32'd0);
        chk("R7 int_en",    32'(int_en_o),   32'd1);
        idle();
        chk("R8 ret one cycle", 32'(redirect_o), 32'd0);
    endtask

    task automatic t_vectored();
        vec_mode_i = 1'b1;
        for (int c = 0; c < 3; c++) begin
            step(c == 0, c == 1, c == 2, 1'b0, 32'h0000_2000 + 32'(c));
            chk("R6 redirect", 32'(redirect_o), 32'd1);
            chk("R6 vector pc", redirect_pc_o, 32'h80 + (32'(c) << 7));
            chk("R3 code", 32'(cause_o), 32'(c));
            idle();
            leave();
        end
        vec_mode_i = 1'b0;
    endtask

    task automatic t_priority();
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_2100);
        chk("R3 all three", 32'(cause_o), 32'd0);
        idle();
        leave();
        step(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2200);
        chk("R3 trap over irq", 32'(cause_o), 32'd1);
        idle();
        leave();
    endtask

    task automatic t_masked_irq();
        step(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2000);
        idle();
        step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_2abc);
        chk("R4 masked irq redirect", 32'(redirect_o), 32'd0);
        chk("R4 masked irq cause",    32'(cause_o),    32'd1);
        idle();
        chk("R4 masked irq later",    32'(redirect_o), 32'd0);
        chk("R4 masked irq epc",      epc_o,           32'h0000_2000);
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R4 return pc", redirect_pc_o, 32'h0000_2000);
        idle();
    endtask

    task automatic t_ignore_in_redirect();
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_3000);
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_3004);
        chk("R8 no second redirect", 32'(redirect_o), 32'd0);
        chk("R8 cause kept",         32'(cause_o),    32'd0);
        chk("R8 epc kept",           epc_o,           32'h0000_3000);
        leave();
        chk("R8 back to user",       32'(kernel_o),   32'd0);
    endtask

    task automatic t_eret_idle_and_race();
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R9 idle eret redirect", 32'(redirect_o), 32'd0);
        chk("R9 idle eret kernel",   32'(kernel_o),   32'd0);
        chk("R9 idle eret int_en",   32'(int_en_o),   32'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_4000);
        idle();
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_4100);
        chk("R9 trap wins redirect", 32'(redirect_o), 32'd1);
        chk("R9 trap wins pc",       redirect_pc_o,   FIX);
        chk("R9 trap wins cause",    32'(cause_o),    32'd1);
        chk("R9 trap wins epc",      epc_o,           32'h0000_4100);
        idle();
        leave();
        leave();
        chk("R9 final user", 32'(kernel_o), 32'd0);
    endtask

    task automatic t_nested();
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_5000);
        idle();
        step(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_5100);
        chk("R10 nested redirect", 32'(redirect_o), 32'd1);
        chk("R10 nested epc",      epc_o,           32'h0000_5100);
        idle();
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R10 first ret pc",     redirect_pc_o,  32'h0000_5100);
        chk("R10 first ret kernel", 32'(kernel_o),  32'd1);
        chk("R10 first ret int_en", 32'(int_en_o),  32'd0);
        idle();
        chk("R10 gap", 32'(redirect_o), 32'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R10 second ret redirect", 32'(redirect_o), 32'd1);
        chk("R10 second ret kernel",   32'(kernel_o),   32'd0);
        chk("R10 second ret int_en",   32'(int_en_o),   32'd1);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_fixed_entry_and_return();
        t_vectored();
        t_priority();
        t_masked_irq();
        t_ignore_in_redirect();
        t_eret_idle_and_race();
        t_nested();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule